// File: doc/BRIEF.md
# Video Memory Block Copy Engine

This engine moves data around video memory without help from the host. A block copy reads words from one video memory address range and writes them to another. The block length and the stepping direction of each pointer are programmable. A second kind of transfer loads the full sprite attribute table. It reads 256 consecutive words starting at a programmable video memory base and writes them into the sprite table storage, which sits on its own write port. Each sprite occupies four consecutive table words: vertical position, horizontal position, pattern number, then attributes. The engine carries these words through unchanged.

The host controls the engine through 16-bit register writes selected by a 5-bit index. A write to the length register launches a block copy. A write to the table base register arms a table load, which then starts on the next vertical-blank pulse. If the repeat bit is set, the table load runs again on every later blank. The engine moves one word per cycle. Each word is read on one cycle and written on the next, so reads and writes overlap. Two completion flags sit in a status vector, and each flag can drive an interrupt line.

Top module: `vdma_engine`

## Requirements
- R1: After reset `busy`, `status`, both interrupt lines, `vram_re`, `vram_we` and `sat_we` are all low.
- R2: Register index 0x0F is control, 0x10 source, 0x11 destination, 0x12 length and 0x13 table base. A write to any other index changes nothing that can be observed.
- R3: Writing the length value L starts a copy of L+1 words. It reads at the source pointer and writes the read word to the destination pointer on the following cycle. `busy` stays high for exactly L+2 cycles.
- R4: Control bit 2 makes the source pointer decrement, and control bit 3 does the same for the destination pointer. The two bits act independently, and pointers wrap modulo 2^16.
- R5: Completion sets `status` bit 4 for a block copy and bit 3 for a table load. A flag stays set until the next transfer of its own kind starts. `irq_copy` equals status bit 4 AND control bit 1. `irq_sat` equals status bit 3 AND control bit 0.
- R6: Writing the table base arms a table load. No table write occurs before a vertical-blank pulse. Following that pulse, table entries 0 to 255 receive the video memory words at base+0 to base+255, in ascending order, and control bits 2 and 3 are ignored. `busy` lasts 257 cycles.
- R7: When control bit 4 is clear at the time a table load starts, later blanks trigger nothing until the base is written again. When bit 4 is set, every blank triggers a fresh load.
- R8: Register writes made while a transfer is running do not alter that transfer. The pointers, length and direction bits are captured when a transfer starts.
- R9: A blank that arrives during a block copy while a load is armed queues the table load. If both kinds of transfer are pending when the engine goes idle, the table load runs first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 5 | Register index |
| reg_wdata | input | 16 | Register write data |
| vblank | input | 1 | One-cycle vertical-blank pulse |
| vram_re | output | 1 | Video memory read strobe |
| vram_raddr | output | 16 | Video memory read address |
| vram_rdata | input | 16 | Read data, valid the cycle after `vram_re` |
| vram_we | output | 1 | Video memory write strobe |
| vram_waddr | output | 16 | Video memory write address |
| vram_wdata | output | 16 | Video memory write data |
| sat_we | output | 1 | Sprite table write strobe |
| sat_addr | output | 8 | Sprite table word index |
| sat_wdata | output | 16 | Sprite table write data |
| busy | output | 1 | A transfer is running |
| status | output | 5 | Bit 3 marks table load done, bit 4 marks block copy done; other bits are zero |
| irq_sat | output | 1 | Table-load interrupt request |
| irq_copy | output | 1 | Block-copy interrupt request |

## Verification
Block copies are run with all four direction combinations. An ascending-to-ascending copy checks the basic read-to-write pairing and the L+2 busy length. Each decrementing case shows whether the two direction bits are really independent. A copy that runs the source pointer below zero exposes wrong wrap arithmetic. A one-word copy checks the length off-by-one. Table loads are tried with auto-repeat off and on, with reloaded memory between blanks, so a stale or missing repeat shows up in the table contents. A blank and a length write that both land during a copy show whether requests are queued and in which order they run.

// File: rtl/vdma_pkg.sv
package vdma_pkg;

    localparam int unsigned SEL_W = 5;

    // Register indices decoded from reg_sel
    localparam logic [SEL_W-1:0] SEL_CTRL = 5'h0F;
    localparam logic [SEL_W-1:0] SEL_SRC  = 5'h10;
    localparam logic [SEL_W-1:0] SEL_DST  = 5'h11;
    localparam logic [SEL_W-1:0] SEL_LEN  = 5'h12;
    localparam logic [SEL_W-1:0] SEL_BASE = 5'h13;

    // Status vector layout
    localparam int unsigned STATUS_W      = 5;
    localparam int unsigned FLAG_SAT_BIT  = 3;
    localparam int unsigned FLAG_COPY_BIT = 4;

    // Control word, low five bits of the control register
    typedef struct packed {
        logic auto_rep;   // bit 4
        logic dst_down;   // bit 3
        logic src_down;   // bit 2
        logic ie_copy;    // bit 1
        logic ie_sat;     // bit 0
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COPY,
        ST_SAT,
        ST_DRAIN
    } state_t;

    function automatic logic sel_is(input logic we, input logic [SEL_W-1:0] sel,
                                    input logic [SEL_W-1:0] want);
        return we && (sel == want);
    endfunction

endpackage

// File: rtl/vdma_regs.sv
module vdma_regs
    import vdma_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [SEL_W-1:0] sel,
    input  logic [W-1:0]     wdata,
    output ctrl_t            ctrl,
    output logic [W-1:0]     src,
    output logic [W-1:0]     dst,
    output logic [W-1:0]     len,
    output logic [W-1:0]     base,
    output logic             copy_req,
    output logic             arm_set
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            src  <= '0;
            dst  <= '0;
            len  <= '0;
            base <= '0;
        end else begin
            if (sel_is(we, sel, SEL_CTRL)) ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
            if (sel_is(we, sel, SEL_SRC))  src  <= wdata;
            if (sel_is(we, sel, SEL_DST))  dst  <= wdata;
            if (sel_is(we, sel, SEL_LEN))  len  <= wdata;
            if (sel_is(we, sel, SEL_BASE)) base <= wdata;
        end
    end

    // A length write launches a copy; a base write arms a table load.
    // Both act on the value written in the same cycle.
    assign copy_req = sel_is(we, sel, SEL_LEN);
    assign arm_set  = sel_is(we, sel, SEL_BASE);

endmodule

// File: rtl/vdma_ptr.sv
module vdma_ptr #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         load_down,
    input  logic         step,
    output logic [W-1:0] addr
);

    logic down_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr   <= '0;
            down_q <= 1'b0;
        end else if (load) begin
            addr   <= load_val;
            down_q <= load_down;
        end else if (step) begin
            addr <= down_q ? addr - 1'b1 : addr + 1'b1;
        end
    end

endmodule

// File: rtl/vdma_seq.sv
module vdma_seq
    import vdma_pkg::*;
#(
    parameter int unsigned W         = 16,
    parameter int unsigned SAT_WORDS = 256
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         copy_req,
    input  logic         arm_set,
    input  logic         vblank,
    input  ctrl_t        ctrl,
    input  logic [W-1:0] len,
    output logic         load,
    output logic         load_sat,
    output logic         rd_go,
    output logic         wr_valid,
    output logic         mode_sat,
    output logic         busy,
    output logic         flag_sat,
    output logic         flag_copy
);

    localparam logic [W-1:0] SAT_LAST = W'(SAT_WORDS - 1);

    state_t       state;
    logic [W-1:0] remain;
    logic         copy_pend;
    logic         sat_pend;
    logic         armed;
    logic         blank_hit;

    assign busy     = (state != ST_IDLE);
    assign load_sat = (state == ST_IDLE) && sat_pend;
    assign load     = (state == ST_IDLE) && (sat_pend || copy_pend);
    assign rd_go    = (state == ST_COPY) || (state == ST_SAT);

    // A blank queues a table load unless one is already starting or running
    assign blank_hit = vblank && armed && !load_sat && !(busy && mode_sat);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            remain    <= '0;
            copy_pend <= 1'b0;
            sat_pend  <= 1'b0;
            armed     <= 1'b0;
            mode_sat  <= 1'b0;
            wr_valid  <= 1'b0;
            flag_sat  <= 1'b0;
            flag_copy <= 1'b0;
        end else begin
            wr_valid <= rd_go;

            unique case (state)
                ST_IDLE: begin
                    if (sat_pend) begin
                        state    <= ST_SAT;
                        remain   <= SAT_LAST;
                        mode_sat <= 1'b1;
                        sat_pend <= 1'b0;
                        flag_sat <= 1'b0;
                    end else if (copy_pend) begin
                        state     <= ST_COPY;
                        remain    <= len;
                        mode_sat  <= 1'b0;
                        copy_pend <= 1'b0;
                        flag_copy <= 1'b0;
                    end
                end
                ST_COPY, ST_SAT: begin
                    remain <= remain - 1'b1;
                    if (remain == '0) state <= ST_DRAIN;
                end
                ST_DRAIN: begin
                    state <= ST_IDLE;
                    if (mode_sat) flag_sat  <= 1'b1;
                    else          flag_copy <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase

            if (load_sat) armed <= ctrl.auto_rep;
            if (arm_set)  armed <= 1'b1;

            if (blank_hit) sat_pend  <= 1'b1;
            if (copy_req)  copy_pend <= 1'b1;
        end
    end

endmodule

// File: rtl/vdma_engine.sv
module vdma_engine
    import vdma_pkg::*;
#(
    parameter int unsigned W         = 16,
    parameter int unsigned SAT_WORDS = 256,
    localparam int unsigned SAT_AW   = $clog2(SAT_WORDS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_we,
    input  logic [SEL_W-1:0]    reg_sel,
    input  logic [W-1:0]        reg_wdata,
    input  logic                vblank,
    output logic                vram_re,
    output logic [W-1:0]        vram_raddr,
    input  logic [W-1:0]        vram_rdata,
    output logic                vram_we,
    output logic [W-1:0]        vram_waddr,
    output logic [W-1:0]        vram_wdata,
    output logic                sat_we,
    output logic [SAT_AW-1:0]   sat_addr,
    output logic [W-1:0]        sat_wdata,
    output logic                busy,
    output logic [STATUS_W-1:0] status,
    output logic                irq_sat,
    output logic                irq_copy
);

    ctrl_t        ctrl;
    logic [W-1:0] src_r, dst_r, len_r, base_r;
    logic         copy_req, arm_set;
    logic         load, load_sat, rd_go, wr_valid, mode_sat;
    logic         flag_sat, flag_copy;
    logic [W-1:0] rptr, wptr;

    vdma_regs #(.W(W)) regs_u (
        .clk      (clk),
        .rst      (rst),
        .we       (reg_we),
        .sel      (reg_sel),
        .wdata    (reg_wdata),
        .ctrl     (ctrl),
        .src      (src_r),
        .dst      (dst_r),
        .len      (len_r),
        .base     (base_r),
        .copy_req (copy_req),
        .arm_set  (arm_set)
    );

    vdma_seq #(.W(W), .SAT_WORDS(SAT_WORDS)) seq_u (
        .clk       (clk),
        .rst       (rst),
        .copy_req  (copy_req),
        .arm_set   (arm_set),
        .vblank    (vblank),
        .ctrl      (ctrl),
        .len       (len_r),
        .load      (load),
        .load_sat  (load_sat),
        .rd_go     (rd_go),
        .wr_valid  (wr_valid),
        .mode_sat  (mode_sat),
        .busy      (busy),
        .flag_sat  (flag_sat),
        .flag_copy (flag_copy)
    );

    // Read side: table loads always ascend from the base
    vdma_ptr #(.W(W)) rptr_u (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_val  (load_sat ? base_r : src_r),
        .load_down (load_sat ? 1'b0 : ctrl.src_down),
        .step      (rd_go),
        .addr      (rptr)
    );

    // Write side: doubles as the table index during a table load
    vdma_ptr #(.W(W)) wptr_u (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_val  (load_sat ? '0 : dst_r),
        .load_down (load_sat ? 1'b0 : ctrl.dst_down),
        .step      (wr_valid),
        .addr      (wptr)
    );

    assign vram_re    = rd_go;
    assign vram_raddr = rptr;
    assign vram_we    = wr_valid && !mode_sat;
    assign vram_waddr = wptr;
    assign vram_wdata = vram_rdata;
    assign sat_we     = wr_valid && mode_sat;
    assign sat_addr   = wptr[SAT_AW-1:0];
    assign sat_wdata  = vram_rdata;

    always_comb begin
        status                = '0;
        status[FLAG_SAT_BIT]  = flag_sat;
        status[FLAG_COPY_BIT] = flag_copy;
    end

    assign irq_sat  = flag_sat  && ctrl.ie_sat;
    assign irq_copy = flag_copy && ctrl.ie_copy;

endmodule

// File: rtl/vdma_engine_chk.sv
module vdma_engine_chk #(
    parameter int unsigned SAT_AW = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              vram_re,
    input logic              vram_we,
    input logic              sat_we,
    input logic [SAT_AW-1:0] sat_addr,
    input logic [4:0]        status,
    input logic              irq_sat,
    input logic              irq_copy
);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!vram_re && !vram_we && !sat_we));

    // R3
    write_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        vram_we |-> $past(vram_re));

    // R6
    sat_index_step_chk: assert property (@(posedge clk) disable iff (rst)
        (sat_we && $past(sat_we)) |-> (sat_addr == $past(sat_addr) + 1'b1));

    // R6
    one_target_chk: assert property (@(posedge clk) disable iff (rst)
        !(vram_we && sat_we));

    // R5
    copy_flag_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status[4]) |-> !busy);

    // R5
    sat_flag_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status[3]) |-> !busy);

    // R5
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (!irq_copy || status[4]) && (!irq_sat || status[3]));

endmodule

bind vdma_engine vdma_engine_chk #(.SAT_AW(SAT_AW)) chk_u (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .vram_re  (vram_re),
    .vram_we  (vram_we),
    .sat_we   (sat_we),
    .sat_addr (sat_addr),
    .status   (status),
    .irq_sat  (irq_sat),
    .irq_copy (irq_copy)
);

// File: tb/vdma_engine_test.sv
module vdma_engine_test;

    localparam int CLK_PERIOD = 10;
    localparam int MEM_WORDS  = 4096;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_sel = '0;
    logic [15:0] reg_wdata = '0;
    logic        vblank = 1'b0;
    logic        vram_re, vram_we, sat_we, busy, irq_sat, irq_copy;
    logic [15:0] vram_raddr, vram_waddr, vram_wdata, sat_wdata;
    logic [15:0] vram_rdata;
    logic [7:0]  sat_addr;
    logic [4:0]  status;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int sat_hits = 0;
    int vw_hits  = 0;

    logic [15:0] vmem [MEM_WORDS];
    logic [15:0] snap [MEM_WORDS];
    logic [15:0] smem [256];
    logic        fill_go = 1'b0;
    int          fill_seed = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vdma_engine uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .vblank(vblank),
        .vram_re(vram_re), .vram_raddr(vram_raddr), .vram_rdata(vram_rdata),
        .vram_we(vram_we), .vram_waddr(vram_waddr), .vram_wdata(vram_wdata),
        .sat_we(sat_we), .sat_addr(sat_addr), .sat_wdata(sat_wdata),
        .busy(busy), .status(status), .irq_sat(irq_sat), .irq_copy(irq_copy)
    );

    function automatic logic [15:0] pat(input int a, input int s);
        return 16'((a * 37) + (s * 101) + ((a >> 3) * 7) + 16'h0A00);
    endfunction

    // Memory models: video memory with one-cycle read latency, sprite table
    always @(posedge clk) begin
        if (fill_go) begin
            for (int i = 0; i < MEM_WORDS; i++) vmem[i] <= pat(i, fill_seed);
        end else begin
            if (vram_re) vram_rdata <= vmem[vram_raddr[11:0]];
            if (vram_we) vmem[vram_waddr[11:0]] <= vram_wdata;
        end
        if (sat_we) begin
            smem[sat_addr] <= sat_wdata;
            sat_hits <= sat_hits + 1;
        end
        if (vram_we) vw_hits <= vw_hits + 1;
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, got cycle %0d expected completion", cyc);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [4:0] sel, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic fill(input int seed);
        @(negedge clk);
        fill_seed = seed; fill_go = 1'b1;
        @(negedge clk);
        fill_go = 1'b0;
    endtask

    task automatic pulse_blank();
        @(negedge clk);
        vblank = 1'b1;
        @(negedge clk);
        vblank = 1'b0;
    endtask

    task automatic take_snap();
        for (int i = 0; i < MEM_WORDS; i++) snap[i] = vmem[i];
    endtask

    // Counts busy cycles starting from the cycle after a launch
    task automatic count_busy(output int n);
        n = 0;
        @(negedge clk);
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    // Compare a finished copy against the snapshot
    task automatic verify_copy(input logic [15:0] s, input logic [15:0] d, input int n,
                               input bit sdn, input bit ddn, input string req);
        int bad = 0;
        logic [15:0] sa, da, last_act, last_exp;
        last_act = '0; last_exp = '0;
        for (int i = 0; i < n; i++) begin
            sa = sdn ? s - 16'(i) : s + 16'(i);
            da = ddn ? d - 16'(i) : d + 16'(i);
            if (vmem[da[11:0]] !== snap[sa[11:0]]) begin
                bad++;
                last_act = vmem[da[11:0]];
                last_exp = snap[sa[11:0]];
            end
        end
        chk(bad == 0, req, last_act, last_exp);
        da = ddn ? d - 16'(n) : d + 16'(n);
        chk(vmem[da[11:0]] === snap[da[11:0]], {req, " beyond end"}, vmem[da[11:0]], snap[da[11:0]]);
    endtask

    task automatic run_copy(input logic [15:0] s, input logic [15:0] d, input logic [15:0] l,
                            input logic [4:0] ctl, input string req);
        int nb;
        wr_reg(5'h0F, {11'd0, ctl});
        wr_reg(5'h10, s);
        wr_reg(5'h11, d);
        take_snap();
        wr_reg(5'h12, l);
        count_busy(nb);
        chk(nb == int'(l) + 2, {req, " busy length"}, nb, int'(l) + 2);
        verify_copy(s, d, int'(l) + 1, ctl[2], ctl[3], req);
    endtask

    task automatic t_reset();
        chk(busy == 0 && status == 0, "R1 busy/status", {busy, status}, 0);
        chk(!irq_sat && !irq_copy, "R1 irq", {irq_sat, irq_copy}, 0);
        chk(!vram_re && !vram_we && !sat_we, "R1 strobes", {vram_re, vram_we, sat_we}, 0);
    endtask

    task automatic t_basic();
        run_copy(16'h0100, 16'h0400, 16'd15, 5'b00000, "R3 ascending copy");
        chk(status[4] == 1'b1, "R5 copy flag", status, 5'h10);
        chk(irq_copy == 1'b0, "R5 irq masked", irq_copy, 0);
        run_copy(16'h0180, 16'h0480, 16'd0, 5'b00000, "R3 single word");
    endtask

    task automatic t_dirs();
        run_copy(16'h02FF, 16'h0500, 16'd7,  5'b00100, "R4 source down");
        run_copy(16'h0300, 16'h06FF, 16'd9,  5'b01000, "R4 dest down");
        run_copy(16'h03A0, 16'h07A0, 16'd5,  5'b01100, "R4 both down");
        run_copy(16'h0002, 16'h0800, 16'd4,  5'b00100, "R4 source wrap");
    endtask

    task automatic t_irq();
        run_copy(16'h0010, 16'h0900, 16'd3, 5'b00010, "R5 copy with irq");
        chk(irq_copy == 1'b1, "R5 irq_copy set", irq_copy, 1);
        wr_reg(5'h0F, 16'h0000);
        @(negedge clk);
        chk(irq_copy == 1'b0 && status[4], "R5 irq follows enable", {irq_copy, status[4]}, 1);
        wr_reg(5'h12, 16'd3);
        @(negedge clk);
        chk(busy && !status[4], "R5 flag cleared on restart", {busy, status[4]}, 2'b10);
        wait_idle();
    endtask

    task automatic t_ignored();
        wr_reg(5'h10, 16'h0120);
        wr_reg(5'h11, 16'h0A00);
        take_snap();
        wr_reg(5'h14, 16'h0AAA);
        wr_reg(5'h0E, 16'h0055);
        wr_reg(5'h03, 16'h0012);
        repeat (3) @(negedge clk);
        chk(!busy && !vram_we, "R2 unused index starts nothing", {busy, vram_we}, 0);
        wr_reg(5'h12, 16'd6);
        wait_idle();
        verify_copy(16'h0120, 16'h0A00, 7, 1'b0, 1'b0, "R2 unused index kept pointers");
    endtask

    task automatic t_sat_once();
        int h0, nb, bad;
        fill(1);
        wr_reg(5'h0F, 16'h000D);  // bits 2,3 set (ignored), irq enable bit 0
        wr_reg(5'h13, 16'h0C00);
        h0 = sat_hits;
        repeat (5) @(negedge clk);
        chk(sat_hits == h0 && !busy, "R6 armed waits for blank", sat_hits - h0, 0);
        pulse_blank();
        count_busy(nb);
        chk(nb == 257, "R6 table busy length", nb, 257);
        bad = 0;
        for (int i = 0; i < 256; i++) if (smem[i] !== pat(16'h0C00 + i, 1)) bad++;
        chk(bad == 0, "R6 table contents ascend", bad, 0);
        chk(status[3] && irq_sat, "R5 table flag and irq", {status[3], irq_sat}, 2'b11);
        fill(2);
        h0 = sat_hits;
        pulse_blank();
        repeat (10) @(negedge clk);
        chk(sat_hits == h0 && !busy, "R7 no repeat without bit 4", sat_hits - h0, 0);
        chk(smem[5] === pat(16'h0C05, 1), "R7 table unchanged", smem[5], pat(16'h0C05, 1));
    endtask

    task automatic t_sat_auto();
        int bad;
        fill(3);
        wr_reg(5'h0F, 16'h0010);
        wr_reg(5'h13, 16'h0D00);
        pulse_blank();
        wait_idle();
        chk(smem[0] === pat(16'h0D00, 3), "R7 first auto load", smem[0], pat(16'h0D00, 3));
        fill(4);
        pulse_blank();
        wait_idle();
        bad = 0;
        for (int i = 0; i < 256; i++) if (smem[i] !== pat(16'h0D00 + i, 4)) bad++;
        chk(bad == 0, "R7 repeated auto load", bad, 0);
        wr_reg(5'h0F, 16'h0000);
        pulse_blank();   // still armed from last start with bit 4 set
        wait_idle();
    endtask

    task automatic t_midwrite();
        fill(5);
        wr_reg(5'h0F, 16'h0000);
        wr_reg(5'h10, 16'h0200);
        wr_reg(5'h11, 16'h0600);
        take_snap();
        wr_reg(5'h12, 16'd31);
        wr_reg(5'h10, 16'h0350);
        wr_reg(5'h11, 16'h0750);
        wr_reg(5'h0F, 16'h000C);
        wait_idle();
        verify_copy(16'h0200, 16'h0600, 32, 1'b0, 1'b0, "R8 running copy kept settings");
        take_snap();
        wr_reg(5'h12, 16'd3);
        wait_idle();
        verify_copy(16'h0350, 16'h0750, 4, 1'b1, 1'b1, "R8 next start uses new settings");
    endtask

    task automatic t_queue();
        int hs, hv;
        bit sat_first;
        fill(6);
        wr_reg(5'h0F, 16'h0000);
        wr_reg(5'h13, 16'h0E00);
        wr_reg(5'h10, 16'h0100);
        wr_reg(5'h11, 16'h0B00);
        wr_reg(5'h12, 16'd40);
        @(negedge clk);
        pulse_blank();
        wr_reg(5'h12, 16'd2);
        wait_idle();
        hs = sat_hits; hv = vw_hits;
        while (sat_hits == hs && vw_hits == hv) @(negedge clk);
        sat_first = (sat_hits != hs) && (vw_hits == hv);
        chk(sat_first, "R9 table load runs before queued copy", sat_first, 1);
        wait_idle();
        chk(smem[255] === pat(16'h0EFF, 6), "R9 queued table load", smem[255], pat(16'h0EFF, 6));
        hv = vw_hits;
        wait_idle();
        chk(vw_hits - hv == 3, "R9 queued copy ran", vw_hits - hv, 3);
    endtask

    initial begin
        fill_go = 1'b0;
        repeat (3) @(negedge clk);
        fill(0);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_dirs();
        t_irq();
        t_ignored();
        t_sat_once();
        t_sat_auto();
        t_midwrite();
        t_queue();
        finish_run();
    end

endmodule